// File: doc/BRIEF.md
# Smart card channel controller

This block connects one contact smart card to a host. It holds a single byte buffer that serves both the command sent to the card and the reply coming back, and it gives the host a synchronous write/read port into that buffer. The host loads a command, starts a transmit of a given length and, once it is done, arms a receive. The bytes that the card sends back then fill the same buffer from address zero up. The host decides when to reset the card and when a reply is complete. The block parses nothing and negotiates nothing on its own.

All logic runs on one system clock. The card clock is a divided copy of it. Bit timing comes from clock-enable pulses: one pulse per card clock period, and a counter of those pulses that marks bit boundaries and bit centres. The card I/O wire is open-drain. The block either pulls it low (`io_oe`) or releases it, and it reads the wire level on `io_in`.

Top module: `sc_channel`

## Requirements
- R1: `card_clk` has a period of exactly CLK_DIV system clocks and is high for CLK_DIV/2 of them.
- R2: `card_rst_n` is 0 (card held in reset) out of reset. One clock after `host_rst` is sampled, `card_rst_n` equals its inverse.
- R3: Every transmitted character is framed as follows. It starts with a low start bit, then carries 8 data bits LSB first (a 0 bit is driven low) and an even parity bit. Two released guard bit times follow. Each bit lasts CLK_DIV*ETU system clocks.
- R4: A pulse on `tx_start` with a non-zero `tx_len` sends the buffer bytes at addresses 0 to `tx_len`-1, in order and each exactly once. After the last byte `byte_count` equals `tx_len`, the transmit-busy flag clears and the line stays released. A `tx_start` with `tx_len` of 0 is ignored.
- R5: A pulse on `rx_start` sets `byte_count` to 0 and arms receive. Each received character is written to the next buffer address starting at 0, and `byte_count` then increments.
- R6: A received character is sampled at bit centres, timed from the detected falling edge of its start bit. A start bit that is high again at its centre is discarded. A parity mismatch sets the parity-error flag, and the flag stays set until the next `rx_start` or `tx_start`.
- R7: Once DEPTH bytes have been received, further characters are dropped. `byte_count` stays at DEPTH and no buffer location is overwritten.
- R8: `host_rdata` shows the buffer byte at `host_addr` one clock after the address is presented. A `host_we` write is visible in a following read.
- R9: `status` is encoded as {rate[3:0]=1, parity_error, rx_armed, tx_busy, card_in_reset}, with bit 0 as the LSB. Rate code 1 means the default bit time of ETU card clocks. `rx_armed` and `tx_busy` are never both set.
- R10: `io_oe` is asserted only while a transmit is in progress.
- R11: After reset, `byte_count` is 0, `io_oe` is 0, and `status` reads 8'h11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (nominally 33 MHz) |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Buffer write strobe |
| host_addr | input | AW | Buffer address for host write/read |
| host_wdata | input | 8 | Buffer write data |
| host_rdata | output | 8 | Buffer read data, one clock latency |
| tx_start | input | 1 | Start transmit from address 0 |
| tx_len | input | CW | Number of bytes to transmit |
| rx_start | input | 1 | Zero the address counter and arm receive |
| host_rst | input | 1 | 1 holds the card in reset |
| card_clk | output | 1 | Card clock, system clock / CLK_DIV |
| card_rst_n | output | 1 | Card reset, active low |
| io_in | input | 1 | Level of the card I/O wire |
| io_oe | output | 1 | 1 pulls the card I/O wire low |
| byte_count | output | CW | Bytes moved since the counter was last zeroed |
| status | output | 8 | Reset state, direction, parity error, rate code |

## Verification
The bench builds the block with CLK_DIV=2, ETU=8 and DEPTH=32. A bit therefore lasts 16 clocks instead of 2232, and the buffer fills after 32 characters. These values make full framing checks, a transmit of several bytes and an overflow past the buffer end cheap to run. A card model in the bench decodes the transmitted characters at bit centres and sends characters with good parity, bad parity and false start pulses. Sampling at bit centres means that drift in the bit timer would corrupt the decoded bytes.

// File: rtl/sc_channel.sv
module sc_channel #(
  parameter int CLK_DIV = 6,
  parameter int ETU     = 372,
  parameter int DEPTH   = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  input  logic          tx_start,
  input  logic [CW-1:0] tx_len,
  input  logic          rx_start,
  input  logic          host_rst,
  output logic          card_clk,
  output logic          card_rst_n,
  input  logic          io_in,
  output logic          io_oe,
  output logic [CW-1:0] byte_count,
  output logic [7:0]    status
);
  localparam int DW   = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int EW   = $clog2(ETU);
  localparam int HALF = CLK_DIV / 2;

  typedef enum logic [1:0] {IDLE, TX, RX} mode_t;

  mode_t         mode;
  logic [7:0]    mem [DEPTH];
  logic [7:0]    eng_q, sh;
  logic [DW-1:0] cdiv;
  logic [EW-1:0] etu;
  logic [3:0]    idx;
  logic [CW-1:0] ptr, len;
  logic [2:0]    io_s;
  logic          rbusy, perr, tx_act, rx_act;

  wire ctick   = cdiv == DW'(CLK_DIV - 1);
  wire bit_end = ctick && etu == EW'(ETU - 1);
  wire mid     = ctick && etu == EW'(ETU / 2 - 1);
  wire tx_go   = tx_start && tx_len != '0;
  wire fall    = io_s[2] && !io_s[1];
  wire start_d = rx_act && !rbusy && fall;
  wire rx_wr   = rx_act && rbusy && mid && idx == 4'd9 && ptr != CW'(DEPTH);
  wire [2:0] bsel = 3'(idx - 4'd1);

  assign tx_act     = mode == TX;
  assign rx_act     = mode == RX;
  assign card_clk   = cdiv < DW'(HALF);
  assign byte_count = ptr;
  assign status     = {4'h1, perr, rx_act, tx_act, !card_rst_n};
  assign io_oe      = tx_act && (idx == 4'd0
                      || (idx >= 4'd1 && idx <= 4'd8 && !sh[bsel])
                      || (idx == 4'd9 && !(^sh)));

  always_ff @(posedge clk) begin
    if (rx_wr) mem[ptr[AW-1:0]] <= sh;
    else if (host_we) mem[host_addr] <= host_wdata;
    host_rdata <= mem[host_addr];
    eng_q      <= mem[ptr[AW-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cdiv       <= '0;
      etu        <= '0;
      card_rst_n <= 1'b0;
      io_s       <= 3'b111;
    end else begin
      cdiv       <= ctick ? '0 : cdiv + DW'(1);
      card_rst_n <= !host_rst;
      io_s       <= {io_s[1:0], io_in};
      if (tx_go || start_d) etu <= '0;
      else if (ctick)       etu <= (etu == EW'(ETU - 1)) ? '0 : etu + EW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= IDLE;
      ptr   <= '0;
      len   <= '0;
      idx   <= '0;
      sh    <= '0;
      rbusy <= 1'b0;
      perr  <= 1'b0;
    end else if (tx_go) begin
      mode <= TX;
      ptr  <= '0;
      len  <= tx_len;
      idx  <= '0;
      perr <= 1'b0;
    end else if (rx_start) begin
      mode  <= RX;
      ptr   <= '0;
      rbusy <= 1'b0;
      perr  <= 1'b0;
    end else if (tx_act) begin
      if (bit_end) begin
        if (idx == 4'd0) sh <= eng_q;
        if (idx == 4'd11) begin
          idx <= '0;
          ptr <= ptr + CW'(1);
          if (ptr + CW'(1) == len) mode <= IDLE;
        end else idx <= idx + 4'd1;
      end
    end else if (rx_act) begin
      if (start_d) begin
        rbusy <= 1'b1;
        idx   <= '0;
      end else if (rbusy && mid) begin
        if (idx == 4'd0) begin
          if (io_s[1]) rbusy <= 1'b0;
          else idx <= 4'd1;
        end else if (idx <= 4'd8) begin
          sh  <= {io_s[1], sh[7:1]};
          idx <= idx + 4'd1;
        end else begin
          if (io_s[1] != ^sh) perr <= 1'b1;
          if (ptr != CW'(DEPTH)) ptr <= ptr + CW'(1);
          rbusy <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/sc_channel_chk.sv
module sc_channel_chk #(
  parameter int DEPTH = 256,
  parameter int CW    = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] ptr,
  input logic          tx_act,
  input logic          rx_act,
  input logic          io_oe,
  input logic          host_rst,
  input logic          card_rst_n
);
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ptr != $past(ptr) |-> (ptr == $past(ptr) + CW'(1) || ptr == '0)); // R4
  AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= CW'(DEPTH)); // R7
  AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_act |-> !io_oe); // R10
  AST_RST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    host_rst |=> !card_rst_n); // R2
  AST_RST_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rst |=> card_rst_n); // R2
  AST_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_act && rx_act)); // R9
endmodule

bind sc_channel sc_channel_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ptr(ptr), .tx_act(tx_act), .rx_act(rx_act),
  .io_oe(io_oe), .host_rst(host_rst), .card_rst_n(card_rst_n)
);

// File: tb/sim_sc_channel.sv
module sim_sc_channel;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 2, ETU = 8, DEPTH = 32;
  localparam int AW = $clog2(DEPTH), CW = $clog2(DEPTH + 1);
  localparam int BIT = DIV * ETU;
  localparam int NV = 8;
  localparam logic [7:0] VEC [NV] = '{8'hA0, 8'hA4, 8'h00, 8'h00, 8'h02, 8'hFF, 8'h55, 8'h3B};

  logic clk = 0, rst_n = 0, host_we = 0, tx_start = 0, rx_start = 0, host_rst = 1, card_low = 0;
  logic [AW-1:0] host_addr = '0;
  logic [7:0] host_wdata = '0, host_rdata, status;
  logic [CW-1:0] tx_len = '0, byte_count;
  logic card_clk, card_rst_n, io_oe, io_in;
  int errs = 0, checks = 0, oe_in_rx = 0;

  assign io_in = !(card_low || io_oe);
  always #(CLK_PERIOD / 2) clk = !clk;

  sc_channel #(.CLK_DIV(DIV), .ETU(ETU), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .tx_start(tx_start),
    .tx_len(tx_len), .rx_start(rx_start), .host_rst(host_rst),
    .card_clk(card_clk), .card_rst_n(card_rst_n), .io_in(io_in), .io_oe(io_oe),
    .byte_count(byte_count), .status(status));

  always @(negedge clk) if (rst_n && status[2] && io_oe) oe_in_rx++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); host_we = 1; host_addr = AW'(a); host_wdata = d;
    @(negedge clk); host_we = 0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk); host_addr = AW'(a);
    @(negedge clk); d = host_rdata;
  endtask

  task automatic card_send(input logic [7:0] b, input bit bad);
    @(negedge clk); card_low = 1;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      card_low = !b[i];
      repeat (BIT) @(negedge clk);
    end
    card_low = !((^b) ^ bad);
    repeat (BIT) @(negedge clk);
    card_low = 0;
    repeat (2 * BIT) @(negedge clk);
  endtask

  task automatic watch_char(output logic [7:0] b, output bit par, output bit grd, output bit seen);
    logic p;
    bit g1;
    seen = 0; b = '0; par = 0; grd = 0;
    for (int k = 0; k < 4 * BIT; k++) begin
      @(negedge clk);
      if (io_oe) begin seen = 1; break; end
    end
    if (!seen) return;
    repeat (BIT / 2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      repeat (BIT) @(negedge clk);
      b[i] = !io_oe;
    end
    repeat (BIT) @(negedge clk);
    p = !io_oe;
    par = (p == ^b);
    repeat (BIT) @(negedge clk);
    g1 = !io_oe;
    repeat (BIT) @(negedge clk);
    grd = g1 && !io_oe;
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] b, d;
    bit par, grd, seen;
    int rises, highs, oe_seen;
    logic [CW-1:0] cnt0;

    repeat (3) @(negedge clk);
    chk(byte_count == 0, "R11 count", byte_count, 0);
    chk(io_oe == 0, "R11 io_oe", io_oe, 0);
    chk(status == 8'h11, "R11 status", status, 8'h11);
    chk(card_rst_n == 0, "R2 reset value", card_rst_n, 0);
    rst_n = 1;
    @(negedge clk);
    chk(card_rst_n == 0, "R2 held", card_rst_n, 0);

    rises = 0; highs = 0;
    for (int k = 0; k < 10 * DIV; k++) begin
      logic prev;
      prev = card_clk;
      @(negedge clk);
      if (card_clk && !prev) rises++;
      if (card_clk) highs++;
    end
    chk(rises == 10, "R1 period", rises, 10);
    chk(highs == 10 * DIV / 2, "R1 duty", highs, 10 * DIV / 2);

    host_rst = 0;
    @(negedge clk);
    chk(card_rst_n == 1, "R2 release", card_rst_n, 1);
    chk(status == 8'h10, "R9 status released", status, 8'h10);
    host_rst = 1;
    @(negedge clk);
    chk(card_rst_n == 0, "R2 assert", card_rst_n, 0);
    host_rst = 0;

    for (int i = 0; i < NV; i++) wr(i, VEC[i]);
    for (int i = 0; i < NV; i++) begin
      rd(i, d);
      chk(d == VEC[i], "R8 readback", d, VEC[i]);
    end

    @(negedge clk); tx_start = 1; tx_len = CW'(NV);
    @(negedge clk); tx_start = 0;
    chk(status[1] == 1, "R9 tx busy", status, 8'h12);
    for (int i = 0; i < NV; i++) begin
      watch_char(b, par, grd, seen);
      chk(seen, "R4 char present", seen, 1);
      chk(b == VEC[i], "R4 byte order", b, VEC[i]);
      chk(par, "R3 even parity", par, 1);
      chk(grd, "R3 guard released", grd, 1);
    end
    oe_seen = 0;
    for (int k = 0; k < 24 * BIT; k++) begin
      @(negedge clk);
      if (io_oe) oe_seen++;
    end
    chk(oe_seen == 0, "R4 no extra char", oe_seen, 0);
    chk(status[1] == 0, "R4 busy cleared", status[1], 0);
    chk(byte_count == CW'(NV), "R4 count", byte_count, NV);

    @(negedge clk); tx_start = 1; tx_len = '0;
    @(negedge clk); tx_start = 0;
    repeat (4) @(negedge clk);
    chk(status[1] == 0 && io_oe == 0, "R4 zero length ignored", status, 8'h10);
    chk(byte_count == CW'(NV), "R4 zero length count", byte_count, NV);

    @(negedge clk); rx_start = 1;
    @(negedge clk); rx_start = 0;
    chk(byte_count == 0, "R5 count zeroed", byte_count, 0);
    chk(status == 8'h14, "R9 rx armed", status, 8'h14);
    for (int i = 0; i < NV; i++) begin
      card_send(VEC[NV - 1 - i], 0);
      chk(byte_count == CW'(i + 1), "R5 count step", byte_count, i + 1);
    end
    for (int i = 0; i < NV; i++) begin
      rd(i, d);
      chk(d == VEC[NV - 1 - i], "R5 stored byte", d, VEC[NV - 1 - i]);
    end
    chk(status[3] == 0, "R6 no parity error", status[3], 0);

    cnt0 = byte_count;
    @(negedge clk); card_low = 1;
    repeat (2) @(negedge clk); card_low = 0;
    repeat (2 * BIT) @(negedge clk);
    chk(byte_count == cnt0, "R6 false start dropped", byte_count, cnt0);
    card_send(8'hC3, 1);
    chk(status[3] == 1, "R6 parity error flagged", status[3], 1);
    @(negedge clk); rx_start = 1;
    @(negedge clk); rx_start = 0;
    chk(status[3] == 0, "R6 parity error cleared", status[3], 0);

    for (int i = 0; i < DEPTH + 2; i++) card_send(8'(i) ^ 8'h5A, 0);
    chk(byte_count == CW'(DEPTH), "R7 count saturates", byte_count, DEPTH);
    rd(0, d);
    chk(d == 8'h5A, "R7 first not overwritten", d, 8'h5A);
    rd(DEPTH - 1, d);
    chk(d == (8'(DEPTH - 1) ^ 8'h5A), "R7 last stored", d, 8'(DEPTH - 1) ^ 8'h5A);
    chk(oe_in_rx == 0, "R10 released in receive", oe_in_rx, 0);

    @(negedge clk); tx_start = 1; tx_len = CW'(1);
    @(negedge clk); tx_start = 0;
    watch_char(b, par, grd, seen);
    chk(b == 8'h5A, "R4 address restarts", b, 8'h5A);
    repeat (BIT) @(negedge clk);
    chk(byte_count == 1, "R4 single count", byte_count, 1);

    finish_run();
  end
endmodule